// File: doc/BRIEF.md
# Packed Decimal to Binary Integer Converter

The block converts in either direction between a ten-byte signed packed-decimal operand and a 64-bit two's-complement integer. A command is issued with a one-cycle start pulse and a direction bit. The block takes one digit byte per clock and adds one closing cycle for the sign, then pulses done for one cycle. The operand sits in a parallel register vector, so no memory port is involved.

When reading a decimal operand, the converter works from the most significant digit byte down to the least. Each step multiplies the running value by one hundred, then adds the two digits of that byte. The sign is applied in the closing cycle.

When writing a decimal operand, it takes the magnitude of the signed integer. Each step splits off the two lowest decimal digits and places them in the next digit byte, starting at the least significant byte. The closing cycle writes the sign byte. Out-of-range digits and out-of-range magnitudes are flagged rather than refused.

Top module: `bcd_int_conv`

## Requirements
- R1: After reset, busy_o, done_o, bad_digit_o and ovf_o are 0, and int_o and bcd_o are all zero.
- R2: In decode mode (dir_i=0), bytes 0..8 of bcd_i hold 18 digits. Byte 0 (bits 7:0) holds the least significant pair. Within a byte, bits 3:0 are the lower-order digit and bits 7:4 the next higher one. The magnitude is the sum over byte k of (high*10+low)*100^k.
- R3: In decode mode, bit 79 (bit 7 of byte 9) set makes int_o the two's-complement negation of the magnitude. Bits 78:72 have no effect.
- R4: In encode mode (dir_i=1), bcd_o bytes 0..8 receive the 18 lowest decimal digits of |int_i|, in the R2 layout. The magnitude of -2^63 is taken as 2^63.
- R5: In encode mode, byte 9 of bcd_o is written as 0x80 when int_i is negative and as 0x00 otherwise.
- R6: done_o is high for exactly one cycle, in the tenth cycle after the clock edge that accepts start_i. busy_o is high from the cycle after acceptance until done_o rises.
- R7: A start_i pulse while busy_o is high is ignored. The running command completes with its original operands and timing.
- R8: In decode mode, any digit nibble above 9 sets bad_digit_o with done_o. int_o still receives the value from the R2 formula using the raw nibble values.
- R9: In encode mode, a magnitude of 10^18 or more sets ovf_o. The digit bytes still hold the magnitude modulo 10^18.
- R10: Both flags are cleared by the acceptance of the next command. bad_digit_o is 0 in the cycle after acceptance.
- R11: A decode command leaves bcd_o unchanged and an encode command leaves int_o unchanged. While the block is idle and not started, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command pulse, accepted when idle |
| dir_i | input | 1 | 0 = decimal to integer, 1 = integer to decimal |
| bcd_i | input | 80 | Packed decimal operand for decoding |
| int_i | input | 64 | Signed integer operand for encoding |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| int_o | output | 64 | Decoded signed integer |
| bcd_o | output | 80 | Encoded packed decimal operand |
| bad_digit_o | output | 1 | A nibble above 9 was seen while decoding |
| ovf_o | output | 1 | Encoding magnitude did not fit 18 digits |

## Verification
Errors in the byte counter or the step sequencing are visible at the ports in the completion cycle. They show as digit pairs in the wrong byte, in reversed nibble order, or multiplied by the wrong power of a hundred. A stuck sequencer shows earlier, because done_o does not arrive exactly ten cycles after acceptance. A sign latched at the wrong moment, or a second start that was not ignored, changes the result of that same command. A flag not cleared at acceptance is seen one cycle later.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  typedef enum logic [1:0] {
    CV_IDLE = 2'd0,
    CV_RUN  = 2'd1,
    CV_SIGN = 2'd2
  } cv_state_e;

  // 10^n as a wide constant, computed rather than tabulated
  function automatic logic [127:0] pow10(input int n);
    logic [127:0] v;
    v = 128'd1;
    for (int i = 0; i < n; i++) v = v * 128'd10;
    return v;
  endfunction

endpackage

// File: rtl/bcd_conv_ctrl.sv
module bcd_conv_ctrl
  import bcd_conv_pkg::*;
#(
  parameter int DIGIT_BYTES = 9,
  localparam int CW = $clog2(DIGIT_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          accept_o,
  output logic          step_o,
  output logic          finish_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(DIGIT_BYTES - 1);

  cv_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    accept_o = (state_q == CV_IDLE) && start_i;
    step_o   = (state_q == CV_RUN);
    finish_o = (state_q == CV_SIGN);
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = finish_o;
    unique case (state_q)
      CV_IDLE: begin
        if (accept_o) begin
          state_d = CV_RUN;
          cnt_d   = '0;
        end
      end
      CV_RUN: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == LAST) state_d = CV_SIGN;
      end
      CV_SIGN: state_d = CV_IDLE;
      default: state_d = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CV_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != CV_IDLE);
  assign done_o = done_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/bcd_load_step.sv
module bcd_load_step #(
  parameter int INT_W = 64
) (
  input  logic [INT_W-1:0] acc_i,
  input  logic [7:0]       pair_i,
  output logic [INT_W-1:0] acc_o,
  output logic             bad_o
);

  logic [3:0] hi, lo;

  always_comb begin
    hi    = pair_i[7:4];
    lo    = pair_i[3:0];
    acc_o = acc_i * INT_W'(100) + INT_W'(hi) * INT_W'(10) + INT_W'(lo);
    bad_o = (hi > 4'd9) || (lo > 4'd9);
  end

endmodule

// File: rtl/bcd_store_step.sv
module bcd_store_step #(
  parameter int INT_W = 64
) (
  input  logic [INT_W-1:0] mag_i,
  output logic [INT_W-1:0] quo_o,
  output logic [7:0]       pair_o
);

  logic [6:0] rem;

  always_comb begin
    quo_o  = mag_i / INT_W'(100);
    rem    = 7'(mag_i - quo_o * INT_W'(100));
    pair_o = {4'(rem / 7'd10), 4'(rem % 7'd10)};
  end

endmodule

// File: rtl/bcd_int_conv.sv
module bcd_int_conv
  import bcd_conv_pkg::*;
#(
  parameter int INT_W       = 64,
  parameter int DIGIT_BYTES = 9,
  localparam int DIGIT_W    = DIGIT_BYTES * 8,
  localparam int BCD_W      = DIGIT_W + 8,
  localparam int CW         = $clog2(DIGIT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [BCD_W-1:0] bcd_i,
  input  logic [INT_W-1:0] int_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [INT_W-1:0] int_o,
  output logic [BCD_W-1:0] bcd_o,
  output logic             bad_digit_o,
  output logic             ovf_o
);

  localparam logic [INT_W-1:0] LIMIT = INT_W'(pow10(2 * DIGIT_BYTES));
  localparam logic [CW-1:0]    TOP   = CW'(DIGIT_BYTES - 1);

  logic          accept, step, finish;
  logic [CW-1:0] cnt;

  logic               dir_q, dir_d;
  logic               neg_q, neg_d;
  logic [DIGIT_W-1:0] wrk_q, wrk_d;
  logic [INT_W-1:0]   acc_q, acc_d;
  logic [INT_W-1:0]   mag_q, mag_d;
  logic [INT_W-1:0]   int_q, int_d;
  logic [BCD_W-1:0]   bcd_q, bcd_d;
  logic               bad_q, bad_d;
  logic               ovf_q, ovf_d;

  logic [CW-1:0]    ld_idx;
  logic [INT_W-1:0] ld_acc, st_quo, in_mag;
  logic [7:0]       st_pair;
  logic             ld_bad;

  bcd_conv_ctrl #(.DIGIT_BYTES(DIGIT_BYTES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .accept_o (accept),
    .step_o   (step),
    .finish_o (finish),
    .cnt_o    (cnt)
  );

  assign ld_idx = TOP - cnt;

  bcd_load_step #(.INT_W(INT_W)) u_load (
    .acc_i  (acc_q),
    .pair_i (wrk_q[ld_idx*8 +: 8]),
    .acc_o  (ld_acc),
    .bad_o  (ld_bad)
  );

  bcd_store_step #(.INT_W(INT_W)) u_store (
    .mag_i  (mag_q),
    .quo_o  (st_quo),
    .pair_o (st_pair)
  );

  assign in_mag = int_i[INT_W-1] ? (~int_i + INT_W'(1)) : int_i;

  always_comb begin
    dir_d = dir_q;
    neg_d = neg_q;
    wrk_d = wrk_q;
    acc_d = acc_q;
    mag_d = mag_q;
    int_d = int_q;
    bcd_d = bcd_q;
    bad_d = bad_q;
    ovf_d = ovf_q;
    if (accept) begin
      dir_d = dir_i;
      acc_d = '0;
      bad_d = 1'b0;
      if (dir_i) begin
        neg_d = int_i[INT_W-1];
        mag_d = in_mag;
        wrk_d = '0;
        ovf_d = (in_mag >= LIMIT);
      end else begin
        neg_d = bcd_i[BCD_W-1];
        mag_d = '0;
        wrk_d = bcd_i[DIGIT_W-1:0];
        ovf_d = 1'b0;
      end
    end
    if (step) begin
      if (dir_q) begin
        mag_d = st_quo;
        wrk_d[cnt*8 +: 8] = st_pair;
      end else begin
        acc_d = ld_acc;
        bad_d = bad_q | ld_bad;
      end
    end
    if (finish) begin
      if (dir_q) bcd_d = {(neg_q ? 8'h80 : 8'h00), wrk_q};
      else       int_d = neg_q ? (~acc_q + INT_W'(1)) : acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      neg_q <= 1'b0;
      wrk_q <= '0;
      acc_q <= '0;
      mag_q <= '0;
      int_q <= '0;
      bcd_q <= '0;
      bad_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      neg_q <= neg_d;
      wrk_q <= wrk_d;
      acc_q <= acc_d;
      mag_q <= mag_d;
      int_q <= int_d;
      bcd_q <= bcd_d;
      bad_q <= bad_d;
      ovf_q <= ovf_d;
    end
  end

  assign int_o       = int_q;
  assign bcd_o       = bcd_q;
  assign bad_digit_o = bad_q;
  assign ovf_o       = ovf_q;

endmodule

// File: rtl/bcd_int_conv_chk.sv
module bcd_int_conv_chk #(
  parameter int INT_W       = 64,
  parameter int DIGIT_BYTES = 9,
  localparam int BCD_W      = DIGIT_BYTES * 8 + 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [INT_W-1:0] int_o,
  input logic [BCD_W-1:0] bcd_o,
  input logic             bad_digit_o
);

  localparam int LAT = DIGIT_BYTES + 1;

  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= 8'd1;
    else if (busy_o)             run_cnt <= run_cnt + 8'd1;
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: busy ends exactly when done appears
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R6, R7: completion latency counted from the accepting edge
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == 8'(LAT + 1)));

  // R11: outputs hold while idle without a start
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(int_o) && $stable(bcd_o)));

  // R10: digit flag cleared once a command is accepted
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> !bad_digit_o);

  // R5: the sign byte only ever holds 0x80 or 0x00
  p_sign_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_o[BCD_W-2 -: 7] == 7'd0);

endmodule

bind bcd_int_conv bcd_int_conv_chk #(
  .INT_W       (INT_W),
  .DIGIT_BYTES (DIGIT_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .int_o       (int_o),
  .bcd_o       (bcd_o),
  .bad_digit_o (bad_digit_o)
);

// File: tb/sim_bcd_int_conv.sv
`timescale 1ns/1ps
module sim_bcd_int_conv;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, dir_i;
  logic [79:0] bcd_i;
  logic [63:0] int_i;
  logic        busy_o, done_o, bad_digit_o, ovf_o;
  logic [63:0] int_o;
  logic [79:0] bcd_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bcd_int_conv u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .bcd_i(bcd_i), .int_i(int_i), .busy_o(busy_o), .done_o(done_o),
    .int_o(int_o), .bcd_o(bcd_o), .bad_digit_o(bad_digit_o), .ovf_o(ovf_o)
  );

  task automatic check(input bit ok, input string req, input [79:0] act, input [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_load(input [79:0] b, output bit badd);
    logic [63:0] acc = 64'd0;
    badd = 1'b0;
    for (int k = 8; k >= 0; k--) begin
      logic [3:0] hi = b[k*8+4 +: 4];
      logic [3:0] lo = b[k*8 +: 4];
      if (hi > 9 || lo > 9) badd = 1'b1;
      acc = acc * 64'd100 + 64'(hi) * 64'd10 + 64'(lo);
    end
    return b[79] ? -acc : acc;
  endfunction

  function automatic logic [79:0] model_store(input [63:0] v, output bit ov);
    logic [63:0] m = v[63] ? -v : v;
    logic [79:0] r = '0;
    ov = (m >= 64'd1000000000000000000);
    for (int k = 0; k < 9; k++) begin
      r[k*8 +: 4] = 4'(m % 64'd10); m = m / 64'd10;
      r[k*8+4 +: 4] = 4'(m % 64'd10); m = m / 64'd10;
    end
    r[79:72] = v[63] ? 8'h80 : 8'h00;
    return r;
  endfunction

  function automatic logic [79:0] rand_bcd(input bit inject);
    logic [79:0] r;
    for (int k = 0; k < 18; k++) r[k*4 +: 4] = 4'($urandom % 10);
    r[79:72] = 8'($urandom);
    if (inject) r[($urandom % 18)*4 +: 4] = 4'(10 + $urandom % 6);
    return r;
  endfunction

  task automatic run(input bit d, input [79:0] b, input [63:0] v, input bit poke);
    logic [63:0] int_before = int_o;
    logic [79:0] bcd_before = bcd_o;
    logic [63:0] exp_i;
    logic [79:0] exp_b;
    bit eb, eo;
    int lat = 0;
    bit early = 0;
    @(negedge clk);
    dir_i = d; bcd_i = b; int_i = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R6 busy after accept", 80'(busy_o), 80'd1);
    while (lat < 10) begin
      if (poke && lat == 3) begin
        start_i = 1'b1; dir_i = ~d; bcd_i = rand_bcd(1'b0); int_i = {$urandom, $urandom};
      end else start_i = 1'b0;
      @(negedge clk);
      lat++;
      if (lat < 10 && done_o) early = 1'b1;
    end
    start_i = 1'b0;
    check(!early && done_o, poke ? "R7 latency with ignored start" : "R6 done at cycle 10",
          80'(done_o), 80'd1);
    check(!busy_o, "R6 busy low at done", 80'(busy_o), 80'd0);
    if (!d) begin
      exp_i = model_load(b, eb);
      check(int_o == exp_i, poke ? "R7 decode result" : "R2 R3 decode value", 80'(int_o), 80'(exp_i));
      check(bad_digit_o == eb, "R8 digit flag", 80'(bad_digit_o), 80'(eb));
      check(bcd_o == bcd_before, "R11 decode keeps bcd_o", bcd_o, bcd_before);
    end else begin
      exp_b = model_store(v, eo);
      check(bcd_o == exp_b, poke ? "R7 encode result" : "R4 R5 encode value", bcd_o, exp_b);
      check(ovf_o == eo, "R9 overflow flag", 80'(ovf_o), 80'(eo));
      check(int_o == int_before, "R11 encode keeps int_o", 80'(int_o), 80'(int_before));
    end
    @(negedge clk);
    check(!done_o, "R6 done one cycle", 80'(done_o), 80'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_i = 1'b0; dir_i = 1'b0; bcd_i = '0; int_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !bad_digit_o && !ovf_o, "R1 reset flags",
          {76'd0, busy_o, done_o, bad_digit_o, ovf_o}, 80'd0);
    check(int_o == 64'd0 && bcd_o == 80'd0, "R1 reset data", bcd_o ^ 80'(int_o), 80'd0);

    // R2 layout: byte0 pair, nibble order
    run(1'b0, 80'h00_000000000000000021, 64'd0, 1'b0);
    run(1'b0, 80'h00_210000000000000000, 64'd0, 1'b0);
    // R2 all nines, R3 negative, ignored sign bits, minus zero
    run(1'b0, 80'h7F_999999999999999999, 64'd0, 1'b0);
    run(1'b0, 80'h80_999999999999999999, 64'd0, 1'b0);
    run(1'b0, 80'h80_000000000000000000, 64'd0, 1'b0);
    // R8 bad nibble, then R10 cleared by a clean command
    run(1'b0, 80'h00_0000000000000000FA, 64'd0, 1'b0);
    check(bad_digit_o == 1'b1, "R8 flag held", 80'(bad_digit_o), 80'd1);
    run(1'b0, 80'h00_000000000000000005, 64'd0, 1'b0);
    check(bad_digit_o == 1'b0, "R10 flag cleared", 80'(bad_digit_o), 80'd0);
    // R4 R5 encode corners, R9 overflow
    run(1'b1, '0, 64'd0, 1'b0);
    run(1'b1, '0, -64'sd1, 1'b0);
    run(1'b1, '0, 64'd999999999999999999, 1'b0);
    run(1'b1, '0, 64'd1000000000000000000, 1'b0);
    check(ovf_o == 1'b1, "R9 overflow boundary", 80'(ovf_o), 80'd1);
    run(1'b1, '0, 64'h8000000000000000, 1'b0);
    run(1'b1, '0, 64'h7FFFFFFFFFFFFFFF, 1'b0);
    run(1'b0, 80'h00_000000000000000001, 64'd0, 1'b0);
    check(ovf_o == 1'b0, "R10 overflow cleared", 80'(ovf_o), 80'd0);
    // R7 start while busy
    run(1'b0, rand_bcd(1'b0), 64'd0, 1'b1);
    run(1'b1, '0, 64'(-64'sd123456789), 1'b1);

    // random mix
    for (int n = 0; n < 60; n++) begin
      if ($urandom % 2) run(1'b0, rand_bcd(($urandom % 5) == 0), 64'd0, ($urandom % 8) == 0);
      else begin
        logic [63:0] v = {$urandom, $urandom};
        if ($urandom % 2) v = v % 64'd1000000000000000000;
        if ($urandom % 2) v = -v;
        run(1'b1, '0, v, ($urandom % 8) == 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule